// File: doc/BRIEF.md
# One-Time Security Register Controller

This block manages a 128-bit security register made of eight 16-bit words. The lower four words hold a factory value that is fixed when the block is built, through a parameter. The upper four words can be programmed by the user. A single lock bit can freeze the user half for good. A host talks to the block through a simple synchronous command bus. Writes carry command bytes or operands, and reads return register contents while identification mode is active.

A program operation takes two write cycles. The first carries the setup byte C0h. The second carries the target address and the data. The new word is the bitwise AND of the old word and the data, so a bit can only go from 1 to 0. Writing the confirm cycle to the lock-word address with data bit 1 equal to 0 clears the lock bit for good. While an accepted operation runs, the block reports busy for `PROG_CYCLES` clock cycles. A refused operation ends at once and sets error flags in the status byte.

The controller has four states. READ is the normal mode, where reads return zero. IDENT is identification mode, where register space is readable. SETUP waits for the confirm cycle. BUSY times an accepted operation. The transitions are:
- READ and IDENT move among themselves on FFh and 90h.
- READ and IDENT go to SETUP on C0h.
- SETUP goes to BUSY on a confirm that is accepted.
- SETUP goes back to the saved mode on a confirm that is refused.
- BUSY goes back to the saved mode when the timer expires.

The user words and the lock bit model non-volatile cells. They are cleared only by `por_n`, not by `rst_n`.

Top module: `otp_secreg_ctrl`

## Requirements
- R1: After `rst_n` the controller is in READ. `busy` is 0, `rdata` is 0000h, and `status` is 80h. In the status byte, bit 7 is ready, bit 4 is program error, bit 1 is lock abort, and every other bit is 0.
- R2: Write command 90h enters IDENT. A read of address 81h–84h then returns factory word 0–3, where word i is `FACTORY[16*i+15:16*i]`. `rdata` is updated on the clock edge that samples `rd_en`. Command FFh returns to READ, where every read returns 0000h.
- R3: In a command cycle only `wdata[7:0]` is decoded. `wdata[15:8]` has no effect, so 1290h enters IDENT and FFC0h starts a program.
- R4: C0h followed by a confirm to a user address 85h–88h, while unlocked, replaces that user word with (old AND data) once the busy period ends.
- R5: The confirm of an accepted operation holds `busy` at 1 and status bit 7 at 0 for exactly `PROG_CYCLES` cycles, starting the cycle after the confirm. Writes during that period are ignored.
- R6: A confirm to an address outside 80h–88h, or one with any address bit above bit 7 set, sets status bit 4 only. It starts no busy period and changes no word.
- R7: A confirm to a factory address 81h–84h sets status bits 4 and 1 and changes nothing.
- R8: A confirm to 80h with data bit 1 = 0 locks the user half. Data bit 1 = 1 leaves it unlocked. Once locked, a confirm to 85h–88h sets status bits 4 and 1 and leaves the word unchanged.
- R9: The user words and the lock bit keep their values across `rst_n`. Only `por_n` restores the user words to FFFFh and the lock bit to unlocked.
- R10: The error flags stay set until the next C0h is accepted in READ or IDENT, which clears both flags.
- R11: In IDENT, address 80h reads 0002h when unlocked and 0000h when locked. Addresses outside register space, including those with high address bits set, read 0000h.
- R12: When an operation ends, whether it completed or was refused, the controller returns to the mode (READ or IDENT) in which C0h was written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the control logic |
| por_n | input | 1 | Asynchronous active-low power-on clear of the stored words and lock bit |
| wr_en | input | 1 | Write cycle strobe (command or confirm) |
| rd_en | input | 1 | Read strobe |
| addr | input | ADDR_W | Word address for reads and confirm cycles |
| wdata | input | 16 | Command byte in bits 7:0, or program data |
| rdata | output | 16 | Registered read data |
| busy | output | 1 | An accepted operation is in progress |
| status | output | 8 | Ready, program-error and lock-abort flags |

## Verification
The checker assumes that `rd_en` and `wr_en` are single-cycle strobes. It also assumes that `por_n` is never released while `rst_n` is still high. That way the non-volatile cells and the control logic leave reset together, and the sticky-flag and frozen-flag properties see a clean history. The bench always drives both resets low together, lifts them on a falling clock edge, and raises a strobe for one cycle at a time. It issues a write during a busy period only as a deliberate test of the ignore rule.

// File: rtl/otp_pkg.sv
package otp_pkg;

    typedef enum logic [1:0] {
        ST_READ  = 2'd0,
        ST_IDENT = 2'd1,
        ST_SETUP = 2'd2,
        ST_BUSY  = 2'd3
    } ctl_state_t;

    typedef enum logic [1:0] {
        AR_NONE  = 2'd0,
        AR_LOCK  = 2'd1,
        AR_FACT  = 2'd2,
        AR_USER  = 2'd3
    } area_t;

    localparam logic [7:0] CMD_READ  = 8'hFF;
    localparam logic [7:0] CMD_IDENT = 8'h90;
    localparam logic [7:0] CMD_PROG  = 8'hC0;

    localparam logic [7:0] LOCK_ADDR = 8'h80;
    localparam int         LOCK_BIT  = 1;

    localparam int SB_READY = 7;
    localparam int SB_PERR  = 4;
    localparam int SB_LOCKA = 1;

endpackage

// File: rtl/otp_addr_decode.sv
module otp_addr_decode
    import otp_pkg::*;
#(
    parameter int ADDR_W     = 21,
    parameter int HALF_WORDS = 4,
    parameter int IDX_W      = $clog2(HALF_WORDS)
) (
    input  logic [ADDR_W-1:0] addr,
    output area_t             area,
    output logic [IDX_W-1:0]  fact_idx,
    output logic [IDX_W-1:0]  user_idx
);

    localparam logic [7:0] FACT_BASE = LOCK_ADDR + 8'd1;
    localparam logic [7:0] USER_BASE = FACT_BASE + 8'(HALF_WORDS);
    localparam logic [7:0] USER_END  = USER_BASE + 8'(HALF_WORDS);

    logic       hi_zero;
    logic [7:0] low;

    assign hi_zero = (addr[ADDR_W-1:8] == '0);
    assign low     = addr[7:0];

    always_comb begin
        area = AR_NONE;
        if (hi_zero) begin
            if (low == LOCK_ADDR) begin
                area = AR_LOCK;
            end else if (low >= FACT_BASE && low < USER_BASE) begin
                area = AR_FACT;
            end else if (low >= USER_BASE && low < USER_END) begin
                area = AR_USER;
            end
        end
    end

    assign fact_idx = IDX_W'(low - FACT_BASE);
    assign user_idx = IDX_W'(low - USER_BASE);

endmodule

// File: rtl/otp_user_store.sv
module otp_user_store #(
    parameter int HALF_WORDS = 4,
    parameter int IDX_W      = $clog2(HALF_WORDS)
) (
    input  logic                         clk,
    input  logic                         por_n,
    input  logic                         wr_en,
    input  logic [IDX_W-1:0]             wr_idx,
    input  logic [15:0]                  wr_data,
    input  logic                         lock_set,
    output logic [HALF_WORDS-1:0][15:0]  words,
    output logic                         unlocked
);

    for (genvar g = 0; g < HALF_WORDS; g++) begin : g_word
        always_ff @(posedge clk or negedge por_n) begin
            if (!por_n) begin
                words[g] <= '1;
            end else if (wr_en && wr_idx == IDX_W'(g)) begin
                words[g] <= words[g] & wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            unlocked <= 1'b1;
        end else if (lock_set) begin
            unlocked <= 1'b0;
        end
    end

endmodule

// File: rtl/otp_busy_timer.sv
module otp_busy_timer #(
    parameter int CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic done
);

    localparam int CNT_W = $clog2(CYCLES + 1);

    logic             run;
    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            run <= 1'b0;
            cnt <= '0;
        end else if (start) begin
            run <= 1'b1;
            cnt <= CNT_W'(CYCLES);
        end else if (run) begin
            cnt <= cnt - 1'b1;
            if (cnt == CNT_W'(1)) begin
                run <= 1'b0;
            end
        end
    end

    assign done = run && (cnt == CNT_W'(1));

endmodule

// File: rtl/otp_secreg_ctrl.sv
module otp_secreg_ctrl
    import otp_pkg::*;
#(
    parameter int              ADDR_W      = 21,
    parameter int              HALF_WORDS  = 4,
    parameter int              PROG_CYCLES = 8,
    parameter logic [63:0]     FACTORY     = 64'h0F1E_2D3C_4B5A_6978
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [15:0]       wdata,
    output logic [15:0]       rdata,
    output logic              busy,
    output logic [7:0]        status
);

    localparam int IDX_W = $clog2(HALF_WORDS);

    ctl_state_t state, state_nx;
    area_t      area;
    logic [IDX_W-1:0] fact_idx, user_idx;

    logic [HALF_WORDS-1:0][15:0] user_words;
    logic                        user_unlocked;

    logic             ret_ident;
    logic             perr_q, locka_q;
    logic             pend_lock;
    logic [IDX_W-1:0] pend_idx;
    logic [15:0]      pend_data;

    logic       tmr_done;
    logic [7:0] cmd;
    logic       cmd_state;
    logic       setup_take;
    logic       confirm;
    logic       accept;
    logic [15:0] rd_word;

    assign cmd        = wdata[7:0];
    assign cmd_state  = (state == ST_READ) || (state == ST_IDENT);
    assign setup_take = cmd_state && wr_en && (cmd == CMD_PROG);
    assign confirm    = (state == ST_SETUP) && wr_en;
    assign accept     = (area == AR_LOCK) || ((area == AR_USER) && user_unlocked);

    otp_addr_decode #(
        .ADDR_W     (ADDR_W),
        .HALF_WORDS (HALF_WORDS),
        .IDX_W      (IDX_W)
    ) i_decode (
        .addr     (addr),
        .area     (area),
        .fact_idx (fact_idx),
        .user_idx (user_idx)
    );

    otp_busy_timer #(
        .CYCLES (PROG_CYCLES)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .start (confirm && accept),
        .done  (tmr_done)
    );

    otp_user_store #(
        .HALF_WORDS (HALF_WORDS),
        .IDX_W      (IDX_W)
    ) i_store (
        .clk      (clk),
        .por_n    (por_n),
        .wr_en    (tmr_done && !pend_lock),
        .wr_idx   (pend_idx),
        .wr_data  (pend_data),
        .lock_set (tmr_done && pend_lock && !pend_data[LOCK_BIT]),
        .words    (user_words),
        .unlocked (user_unlocked)
    );

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_READ;
        end else begin
            state <= state_nx;
        end
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_READ, ST_IDENT: begin
                if (wr_en) begin
                    if (cmd == CMD_READ) begin
                        state_nx = ST_READ;
                    end else if (cmd == CMD_IDENT) begin
                        state_nx = ST_IDENT;
                    end else if (cmd == CMD_PROG) begin
                        state_nx = ST_SETUP;
                    end
                end
            end
            ST_SETUP: begin
                if (wr_en) begin
                    if (accept) begin
                        state_nx = ST_BUSY;
                    end else begin
                        state_nx = ret_ident ? ST_IDENT : ST_READ;
                    end
                end
            end
            ST_BUSY: begin
                if (tmr_done) begin
                    state_nx = ret_ident ? ST_IDENT : ST_READ;
                end
            end
            default: state_nx = ST_READ;
        endcase
    end

    // Read source selection
    always_comb begin
        rd_word = '0;
        unique case (area)
            AR_LOCK: rd_word = {14'd0, user_unlocked, 1'b0};
            AR_FACT: rd_word = FACTORY[16*fact_idx +: 16];
            AR_USER: rd_word = user_words[user_idx];
            default: rd_word = '0;
        endcase
    end

    // Registered outputs and operation context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata     <= '0;
            ret_ident <= 1'b0;
            perr_q    <= 1'b0;
            locka_q   <= 1'b0;
            pend_lock <= 1'b0;
            pend_idx  <= '0;
            pend_data <= '0;
        end else begin
            if (rd_en) begin
                rdata <= (state == ST_IDENT) ? rd_word : 16'h0000;
            end
            if (setup_take) begin
                ret_ident <= (state == ST_IDENT);
                perr_q    <= 1'b0;
                locka_q   <= 1'b0;
            end
            if (confirm) begin
                pend_lock <= (area == AR_LOCK);
                pend_idx  <= user_idx;
                pend_data <= wdata;
                if (area == AR_NONE) begin
                    perr_q <= 1'b1;
                end else if (!accept) begin
                    perr_q  <= 1'b1;
                    locka_q <= 1'b1;
                end
            end
        end
    end

    assign busy   = (state == ST_BUSY);
    assign status = {!busy, 2'b00, perr_q, 2'b00, locka_q, 1'b0};

endmodule

// File: rtl/otp_secreg_chk.sv
module otp_secreg_chk #(
    parameter int PROG_CYCLES = 8
) (
    input logic        clk,
    input logic        rst_n,
    input logic        por_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [15:0] rdata,
    input logic        busy,
    input logic [6:0]  flags,
    input logic        unlocked
);

    int busy_run;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_run <= 0;
        end else if (busy) begin
            busy_run <= busy_run + 1;
        end else begin
            busy_run <= 0;
        end
    end

    // R5: a busy period never outlasts the programmed length
    p_busy_len_r5: assert property (@(posedge clk) disable iff (!rst_n)
        busy_run <= PROG_CYCLES)
        else $error("busy longer than PROG_CYCLES");

    // R5: busy only begins right after a write cycle
    p_busy_after_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !$past(busy)) |-> $past(wr_en))
        else $error("busy began without a confirm write");

    // R5: flags are frozen inside a busy period
    p_flags_frozen_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(flags))
        else $error("flags changed while busy");

    // R7: a lock abort always carries a program error
    p_abort_has_perr_r7: assert property (@(posedge clk) disable iff (!rst_n)
        flags[1] |-> flags[4])
        else $error("lock abort without program error");

    // R10: the program-error flag only clears after a write cycle
    p_perr_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!flags[4] && $past(flags[4])) |-> $past(wr_en))
        else $error("program error cleared without a command");

    // R2: reads outside identification mode return zero
    p_busy_read_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && rd_en) |=> (rdata == 16'h0000))
        else $error("read during busy returned data");

    // R9: once locked, the lock bit stays cleared until power-on clear
    p_lock_permanent_r9: assert property (@(posedge clk) disable iff (!por_n)
        !unlocked |=> !unlocked)
        else $error("lock bit was set again");

endmodule

bind otp_secreg_ctrl otp_secreg_chk #(
    .PROG_CYCLES (PROG_CYCLES)
) i_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .por_n    (por_n),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .rdata    (rdata),
    .busy     (busy),
    .flags    (status[6:0]),
    .unlocked (user_unlocked)
);

// File: tb/test_otp_secreg_ctrl.sv
module test_otp_secreg_ctrl;

    localparam int          ADDR_W = 21;
    localparam int          PCYC   = 6;
    localparam logic [63:0] FACT   = 64'h4444_3333_2222_1111;

    localparam logic [1:0] OP_WR = 2'd0;
    localparam logic [1:0] OP_RD = 2'd1;
    localparam logic [1:0] OP_ST = 2'd2;

    // fields: req[45:42] op[41:40] addr[39:32] data[31:16] exp[15:0]
    localparam int NV = 25;
    localparam logic [45:0] VEC [NV] = '{
        {4'd3,  OP_WR, 8'h00, 16'h1290, 16'h0000}, // R3 upper byte ignored, enter ident
        {4'd2,  OP_RD, 8'h81, 16'h0000, 16'h1111}, // R2 factory word 0
        {4'd2,  OP_RD, 8'h84, 16'h0000, 16'h4444}, // R2 factory word 3
        {4'd9,  OP_RD, 8'h85, 16'h0000, 16'hFFFF}, // R9 erased after power-on
        {4'd11, OP_RD, 8'h80, 16'h0000, 16'h0002}, // R11 lock word unlocked
        {4'd4,  OP_WR, 8'h00, 16'h00C0, 16'h0000}, // R4 setup
        {4'd4,  OP_WR, 8'h85, 16'hA5F0, 16'h0000}, // R4 confirm
        {4'd12, OP_RD, 8'h85, 16'h0000, 16'hA5F0}, // R12 still in ident
        {4'd3,  OP_WR, 8'h00, 16'hFFC0, 16'h0000}, // R3 setup with junk high byte
        {4'd4,  OP_WR, 8'h85, 16'h0FFF, 16'h0000}, // R4 confirm
        {4'd4,  OP_RD, 8'h85, 16'h0000, 16'h05F0}, // R4 AND of old and new
        {4'd4,  OP_ST, 8'h00, 16'h0000, 16'h0080}, // R4 clean status
        {4'd7,  OP_WR, 8'h00, 16'h00C0, 16'h0000}, // R7 setup
        {4'd7,  OP_WR, 8'h82, 16'h0000, 16'h0000}, // R7 factory target
        {4'd7,  OP_ST, 8'h00, 16'h0000, 16'h0092}, // R7 both flags
        {4'd7,  OP_RD, 8'h82, 16'h0000, 16'h2222}, // R7 unchanged
        {4'd10, OP_WR, 8'h00, 16'h00C0, 16'h0000}, // R10 setup clears flags
        {4'd10, OP_ST, 8'h00, 16'h0000, 16'h0080}, // R10 cleared
        {4'd6,  OP_WR, 8'h8A, 16'h0000, 16'h0000}, // R6 out of space
        {4'd6,  OP_ST, 8'h00, 16'h0000, 16'h0090}, // R6 program error only
        {4'd6,  OP_RD, 8'h8A, 16'h0000, 16'h0000}, // R6 outside reads zero
        {4'd2,  OP_WR, 8'h00, 16'h00FF, 16'h0000}, // R2 back to read mode
        {4'd2,  OP_RD, 8'h81, 16'h0000, 16'h0000}, // R2 normal reads zero
        {4'd2,  OP_WR, 8'h00, 16'h0090, 16'h0000}, // R2 ident again
        {4'd9,  OP_RD, 8'h86, 16'h0000, 16'hFFFF}  // R9 untouched word erased
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              por_n = 1'b0;
    logic              wr_en = 1'b0;
    logic              rd_en = 1'b0;
    logic [ADDR_W-1:0] addr = '0;
    logic [15:0]       wdata = '0;
    logic [15:0]       rdata;
    logic              busy;
    logic [7:0]        status;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    otp_secreg_ctrl #(
        .ADDR_W      (ADDR_W),
        .HALF_WORDS  (4),
        .PROG_CYCLES (PCYC),
        .FACTORY     (FACT)
    ) i_otp_secreg_ctrl (
        .clk    (clk),
        .rst_n  (rst_n),
        .por_n  (por_n),
        .wr_en  (wr_en),
        .rd_en  (rd_en),
        .addr   (addr),
        .wdata  (wdata),
        .rdata  (rdata),
        .busy   (busy),
        .status (status)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_wr(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        addr  = a;
        wdata = d;
        wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_wait(input logic [ADDR_W-1:0] a, input logic [15:0] d);
        bus_wr(a, d);
        for (int k = 0; k < 1000 && busy; k++) @(negedge clk);
    endtask

    task automatic bus_rd(input logic [ADDR_W-1:0] a, output logic [15:0] d);
        addr  = a;
        rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        d = rdata;
    endtask

    task automatic do_reset(input logic power);
        @(negedge clk);
        rst_n = 1'b0;
        if (power) por_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        por_n = 1'b1;
        @(negedge clk);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run did not finish");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] rv;
        int          nb;

        do_reset(1'b1);
        // R1 reset state
        check("R1 status", {8'h00, status}, 16'h0080);
        check("R1 busy", {15'd0, busy}, 16'h0000);
        check("R1 rdata", rdata, 16'h0000);

        for (int i = 0; i < NV; i++) begin
            string tag;
            tag = $sformatf("R%0d vec%0d", VEC[i][45:42], i);
            unique case (VEC[i][41:40])
                OP_WR: wr_wait({13'd0, VEC[i][39:32]}, VEC[i][31:16]);
                OP_RD: begin
                    bus_rd({13'd0, VEC[i][39:32]}, rv);
                    check(tag, rv, VEC[i][15:0]);
                end
                default: check(tag, {8'h00, status}, VEC[i][15:0]);
            endcase
        end

        // R5 busy length, ready bit, write ignored while busy; R12 return to read mode
        bus_wr(21'h0, 16'h00FF);
        bus_wr(21'h0, 16'h00C0);
        bus_wr(21'h86, 16'h00FF);
        check("R5 ready low while busy", {15'd0, status[7]}, 16'h0000);
        nb = 0;
        while (busy && nb < 1000) begin
            if (nb == 1) begin
                wdata = 16'h0090;
                wr_en = 1'b1;
            end else begin
                wr_en = 1'b0;
            end
            nb++;
            @(negedge clk);
        end
        wr_en = 1'b0;
        check("R5 busy cycles", 16'(nb), 16'(PCYC));
        bus_rd(21'h81, rv);
        check("R12/R5 still read mode", rv, 16'h0000);
        check("R5 status after", {8'h00, status}, 16'h0080);
        wr_wait(21'h0, 16'h0090);
        bus_rd(21'h86, rv);
        check("R4 word 86", rv, 16'h00FF);

        // R8 lock semantics
        wr_wait(21'h0, 16'h00C0);
        wr_wait(21'h80, 16'hFFFF);
        bus_rd(21'h80, rv);
        check("R8 bit1 one keeps unlocked", rv, 16'h0002);
        wr_wait(21'h0, 16'h00C0);
        wr_wait(21'h80, 16'hFFFD);
        bus_rd(21'h80, rv);
        check("R8 locked", rv, 16'h0000);
        check("R8 lock status", {8'h00, status}, 16'h0080);
        wr_wait(21'h0, 16'h00C0);
        wr_wait(21'h87, 16'h0000);
        check("R8 abort status", {8'h00, status}, 16'h0092);
        bus_rd(21'h87, rv);
        check("R8 word unchanged", rv, 16'hFFFF);

        // R9 persistence across logic reset
        do_reset(1'b0);
        check("R1 status after reset", {8'h00, status}, 16'h0080);
        wr_wait(21'h0, 16'h0090);
        bus_rd(21'h80, rv);
        check("R9 lock kept", rv, 16'h0000);
        bus_rd(21'h85, rv);
        check("R9 word kept", rv, 16'h05F0);

        // R11 high address bits put a read outside register space
        bus_rd(21'h100081, rv);
        check("R11 high bits", rv, 16'h0000);
        bus_rd(21'h000181, rv);
        check("R11 bit8 set", rv, 16'h0000);

        // R6 confirm with high address bit set
        wr_wait(21'h0, 16'h00C0);
        wr_wait(21'h000185, 16'h0000);
        check("R6 high-bit confirm", {8'h00, status}, 16'h0090);

        // R9 power-on clear
        do_reset(1'b1);
        wr_wait(21'h0, 16'h0090);
        bus_rd(21'h80, rv);
        check("R9 por unlock", rv, 16'h0002);
        bus_rd(21'h85, rv);
        check("R9 por erase", rv, 16'hFFFF);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule